// File: doc/BRIEF.md
# Vectored Interrupt Response Controller

This block collects five interrupt sources and turns the highest-priority pending one into a call request with a fixed entry address for the processor. The five sources are two external request pins (active low), two timer overflow pulses and one serial port. The serial port has separate transmit and receive flags that share one vector. The processor answers a call request with an acknowledge. On that cycle the controller enters its in-service state and removes the request flags that hardware may clear.

Each source clears in its own way. Timer flags and external flags in edge mode drop on acknowledge. External flags in level mode simply follow the pin. The serial flags stay set until a software clear strobe arrives. The in-service state blocks any further call until a return-from-interrupt pulse ends it. An ordinary subroutine return leaves it set. A flag that is still set when service ends is requested again at once.

The call is a long call that saves only the return address. Saving the accumulator or status is left to the service routine.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, callReq is 0, vecAddr is 0, inService is 0 and all six bits of irqFlags are 0. The irqFlags bit order is bit0 external 0, bit1 timer 0, bit2 external 1, bit3 timer 1, bit4 serial transmit, bit5 serial receive.
- R2: The entry addresses are fixed. External 0 gives 0x0003, timer 0 gives 0x000B, external 1 gives 0x0013, timer 1 gives 0x001B, and serial (transmit or receive) gives 0x0023.
- R3: When several enabled sources are pending, the lowest address wins, in the order external 0, timer 0, external 1, timer 1, serial.
- R4: A source can request only while globalEn is 1 and its srcEn bit is 1. The srcEn bit order is the same as irqFlags bits 0..3, and bit4 is serial. A disabled source still latches its flag in irqFlags. With no request, vecAddr is 0.
- R5: When cpuAck is 1 while callReq is 1, inService is 1 from the next cycle. While inService is 1, callReq is 0 and vecAddr is 0, even if new flags arrive.
- R6: An acknowledged timer source has its flag cleared at the acknowledge edge.
- R7: In edge mode (extEdgeMode bit = 1), a 1-to-0 change on extInN sets the flag one clock later, and acknowledge clears it. A pin that stays low does not set the flag again.
- R8: In level mode (extEdgeMode bit = 0), the flag equals the inverse of the pin as sampled at the previous clock, and acknowledge does not clear it.
- R9: serTxDone and serRxDone set their flags. Acknowledge clears neither. Only serTxClr and serRxClr clear them, one flag each.
- R10: retiPulse clears inService at the next edge. retPlain leaves it unchanged.
- R11: A flag that is still set when inService drops raises callReq in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extInN | input | 2 | External request pins, active low |
| extEdgeMode | input | 2 | Per pin: 1 = falling-edge mode, 0 = level mode |
| tmrOvf | input | 2 | Timer overflow pulses |
| serTxDone | input | 1 | Serial transmit-done pulse |
| serRxDone | input | 1 | Serial receive-done pulse |
| serTxClr | input | 1 | Software clear of the transmit flag |
| serRxClr | input | 1 | Software clear of the receive flag |
| srcEn | input | 5 | Per-source enables |
| globalEn | input | 1 | Global interrupt enable |
| cpuAck | input | 1 | Processor accepts the call |
| retiPulse | input | 1 | Return-from-interrupt executed |
| retPlain | input | 1 | Ordinary return executed |
| callReq | output | 1 | Long-call request to the processor |
| vecAddr | output | 16 | Entry address of the selected source |
| inService | output | 1 | In-service (priority status) state |
| irqFlags | output | 6 | Latched request flags |

## Verification
The bench targets the source-specific clearing rules. If the serial flags were cleared on acknowledge, the re-request after return would never appear. If level-mode flags were cleared on acknowledge, a held-low pin would go unserviced. If an edge-mode pin held low kept setting its flag, the same event would be serviced twice. The bench also pulses a plain return during service, which a wrongly coded return would use to end service. It sets many flags at once to catch an inverted priority order, and raises a new flag during service to catch a call leaking past the in-service block.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int N_PAIR = 2;
  localparam int N_SRC = 2 * N_PAIR + 1;
  localparam int N_FLAG = N_SRC + 1;
  localparam int IDX_W = $clog2(N_SRC);

  typedef struct packed {
    logic [N_PAIR-1:0] clrExt;
    logic [N_PAIR-1:0] clrTmr;
  } ackStrobe_t;
endpackage

// File: rtl/irqv_flags.sv
module irqv_flags
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N_PAIR-1:0]   extInN,
  input  logic [N_PAIR-1:0]   extEdgeMode,
  input  logic [N_PAIR-1:0]   tmrOvf,
  input  logic                serTxDone,
  input  logic                serRxDone,
  input  logic                serTxClr,
  input  logic                serRxClr,
  input  logic [N_SRC-1:0]    srcEn,
  input  logic                globalEn,
  input  ackStrobe_t          ackS,
  output logic                anyReq,
  output logic [IDX_W-1:0]    reqIdx,
  output logic [ADDR_W-1:0]   rawVec,
  output logic [N_FLAG-1:0]   flags
);
  logic [N_PAIR-1:0] extPrev;
  logic [N_PAIR-1:0] extFlag;
  logic [N_PAIR-1:0] tmrFlag;
  logic serTxFlag, serRxFlag;
  logic [N_SRC-1:0] req;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= '1;
    else       extPrev <= extInN;
  end

  for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        extFlag[k] <= 1'b0;
      end else if (!extEdgeMode[k]) begin
        extFlag[k] <= ~extInN[k];
      end else if (extPrev[k] && !extInN[k]) begin
        extFlag[k] <= 1'b1;
      end else if (ackS.clrExt[k]) begin
        extFlag[k] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              tmrFlag[k] <= 1'b0;
      else if (tmrOvf[k])     tmrFlag[k] <= 1'b1;
      else if (ackS.clrTmr[k]) tmrFlag[k] <= 1'b0;
    end

    assign req[2*k]   = extFlag[k] & srcEn[2*k];
    assign req[2*k+1] = tmrFlag[k] & srcEn[2*k+1];
    assign flags[2*k]   = extFlag[k];
    assign flags[2*k+1] = tmrFlag[k];

    p_tmr_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ackS.clrTmr[k] && !tmrOvf[k]) |=> !tmrFlag[k]);
    p_level_track_r8: assert property (@(posedge clk) disable iff (!rstN)
      !extEdgeMode[k] |=> (extFlag[k] == !$past(extInN[k])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serTxFlag <= 1'b0;
      serRxFlag <= 1'b0;
    end else begin
      if (serTxDone)     serTxFlag <= 1'b1;
      else if (serTxClr) serTxFlag <= 1'b0;
      if (serRxDone)     serRxFlag <= 1'b1;
      else if (serRxClr) serRxFlag <= 1'b0;
    end
  end

  assign req[N_SRC-1] = (serTxFlag | serRxFlag) & srcEn[N_SRC-1];
  assign flags[N_SRC-1] = serTxFlag;
  assign flags[N_SRC]   = serRxFlag;

  always_comb begin
    reqIdx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) reqIdx = IDX_W'(i);
    end
  end

  assign anyReq = globalEn & (|req);
  assign rawVec = anyReq ? ADDR_W'(VEC_BASE + VEC_STRIDE * int'(reqIdx)) : '0;

  p_ser_tx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (serTxFlag && !serTxClr) |=> serTxFlag);
  p_ser_rx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (serRxFlag && !serRxClr) |=> serRxFlag);
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             anyReq,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             cpuAck,
  input  logic             retiPulse,
  input  logic             retPlain,
  output logic             callReq,
  output logic             inService,
  output ackStrobe_t       ackS
);
  logic take;

  assign callReq = anyReq & ~inService;
  assign take = callReq & cpuAck;

  for (genvar k = 0; k < N_PAIR; k++) begin : g_clr
    assign ackS.clrExt[k] = take && (reqIdx == IDX_W'(2*k));
    assign ackS.clrTmr[k] = take && (reqIdx == IDX_W'(2*k+1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          inService <= 1'b0;
    else if (take)      inService <= 1'b1;
    else if (retiPulse) inService <= 1'b0;
  end

  p_ack_enters_r5: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && cpuAck) |=> inService);
  p_reti_leaves_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inService && retiPulse) |=> !inService);
  p_plain_ret_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inService && retPlain && !retiPulse) |=> inService);
  p_one_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackS));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        extInN,
  input  logic [1:0]        extEdgeMode,
  input  logic [1:0]        tmrOvf,
  input  logic              serTxDone,
  input  logic              serRxDone,
  input  logic              serTxClr,
  input  logic              serRxClr,
  input  logic [4:0]        srcEn,
  input  logic              globalEn,
  input  logic              cpuAck,
  input  logic              retiPulse,
  input  logic              retPlain,
  output logic              callReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              inService,
  output logic [5:0]        irqFlags
);
  ackStrobe_t ackS;
  logic anyReq;
  logic [IDX_W-1:0] reqIdx;
  logic [ADDR_W-1:0] rawVec;

  irqv_flags #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_flags (
    .clk(clk), .rstN(rstN), .extInN(extInN), .extEdgeMode(extEdgeMode),
    .tmrOvf(tmrOvf), .serTxDone(serTxDone), .serRxDone(serRxDone),
    .serTxClr(serTxClr), .serRxClr(serRxClr), .srcEn(srcEn), .globalEn(globalEn),
    .ackS(ackS), .anyReq(anyReq), .reqIdx(reqIdx), .rawVec(rawVec), .flags(irqFlags)
  );

  irqv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .reqIdx(reqIdx), .cpuAck(cpuAck),
    .retiPulse(retiPulse), .retPlain(retPlain), .callReq(callReq),
    .inService(inService), .ackS(ackS)
  );

  assign vecAddr = callReq ? rawVec : '0;

  p_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> globalEn);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] extInN = 2'b11, extEdgeMode = 2'b11, tmrOvf = '0;
  logic serTxDone = 0, serRxDone = 0, serTxClr = 0, serRxClr = 0;
  logic [4:0] srcEn = '0;
  logic globalEn = 0, cpuAck = 0, retiPulse = 0, retPlain = 0;
  logic callReq, inService;
  logic [15:0] vecAddr;
  logic [5:0] irqFlags;
  int tests = 0, failed = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u0 (.*);

  // {raise mask[6], srcEn[5], globalEn, expected callReq, expected vecAddr[16]}
  localparam logic [28:0] VEC_TBL [11] = '{
    {6'b000001, 5'b11111, 1'b1, 1'b1, 16'h0003},
    {6'b000010, 5'b11111, 1'b1, 1'b1, 16'h000B},
    {6'b000100, 5'b11111, 1'b1, 1'b1, 16'h0013},
    {6'b001000, 5'b11111, 1'b1, 1'b1, 16'h001B},
    {6'b010000, 5'b11111, 1'b1, 1'b1, 16'h0023},
    {6'b100000, 5'b11111, 1'b1, 1'b1, 16'h0023},
    {6'b111111, 5'b11111, 1'b1, 1'b1, 16'h0003},
    {6'b001100, 5'b11111, 1'b1, 1'b1, 16'h0013},
    {6'b111110, 5'b11101, 1'b1, 1'b1, 16'h0013},
    {6'b000001, 5'b11111, 1'b0, 1'b0, 16'h0000},
    {6'b110000, 5'b01111, 1'b1, 1'b0, 16'h0000}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; cpuAck = 0; retiPulse = 0; retPlain = 0;
    extInN = 2'b11; tmrOvf = '0; serTxDone = 0; serRxDone = 0;
    serTxClr = 0; serRxClr = 0;
    step(); step();
    rstN = 1;
  endtask

  task automatic raise(logic [5:0] m);
    extInN = ~{m[2], m[0]};
    tmrOvf = {m[3], m[1]};
    serTxDone = m[4];
    serRxDone = m[5];
    step();
    extInN = 2'b11; tmrOvf = '0; serTxDone = 0; serRxDone = 0;
  endtask

  task automatic ack();
    cpuAck = 1; step(); cpuAck = 0;
  endtask

  task automatic reti();
    retiPulse = 1; step(); retiPulse = 0;
  endtask

  initial begin
    doReset();
    chk("R1 callReq", callReq, 0);
    chk("R1 vecAddr", vecAddr, 0);
    chk("R1 inService", inService, 0);
    chk("R1 irqFlags", irqFlags, 0);

    // Table walk: R2 vectors, R3 priority, R4 gating
    for (int i = 0; i < 11; i++) begin
      doReset();
      extEdgeMode = 2'b11;
      raise(VEC_TBL[i][28:23]);
      srcEn = VEC_TBL[i][22:18];
      globalEn = VEC_TBL[i][17];
      #1;
      chk($sformatf("R2/R3/R4 row%0d callReq", i), callReq, VEC_TBL[i][16]);
      chk($sformatf("R2/R3/R4 row%0d vecAddr", i), vecAddr, VEC_TBL[i][15:0]);
      chk($sformatf("R4 row%0d flags latched", i), irqFlags, VEC_TBL[i][28:23]);
    end

    // R5/R6/R10/R11: timer clear, busy block, returns
    doReset(); srcEn = '1; globalEn = 1; extEdgeMode = 2'b11;
    raise(6'b000010);
    chk("R2 tmr0 vec", vecAddr, 16'h000B);
    ack();
    chk("R5 inService set", inService, 1);
    chk("R6 tmr0 cleared", irqFlags[1], 0);
    raise(6'b001000);
    chk("R5 callReq blocked", callReq, 0);
    chk("R5 vecAddr blocked", vecAddr, 0);
    retPlain = 1; step(); retPlain = 0;
    chk("R10 plain ret keeps service", inService, 1);
    reti();
    chk("R10 reti clears", inService, 0);
    chk("R11 re-request", callReq, 1);
    chk("R11 vec tmr1", vecAddr, 16'h001B);
    ack();
    chk("R6 tmr1 cleared", irqFlags[3], 0);
    reti();
    chk("R6 nothing left", callReq, 0);

    // R7 edge mode with pin held low
    doReset(); srcEn = '1; globalEn = 1; extEdgeMode = 2'b11;
    extInN = 2'b10; step();
    chk("R7 edge sets flag", irqFlags[0], 1);
    ack();
    chk("R7 ack clears flag", irqFlags[0], 0);
    step(); step();
    chk("R7 held low no reset", irqFlags[0], 0);
    reti();
    chk("R7 no repeat call", callReq, 0);
    extInN = 2'b11;

    // R8 level mode
    doReset(); srcEn = '1; globalEn = 1; extEdgeMode = 2'b01;
    extInN = 2'b01; step();
    chk("R8 level flag", irqFlags[2], 1);
    chk("R8 vec ext1", vecAddr, 16'h0013);
    ack();
    chk("R8 ack keeps flag", irqFlags[2], 1);
    reti();
    chk("R11 level re-request", callReq, 1);
    extInN = 2'b11; step();
    chk("R8 level follows pin", irqFlags[2], 0);

    // R9 serial flags
    doReset(); srcEn = '1; globalEn = 1; extEdgeMode = 2'b11;
    raise(6'b010000);
    ack();
    chk("R9 ack keeps tx", irqFlags[4], 1);
    reti();
    chk("R11 serial re-request", vecAddr, 16'h0023);
    serTxClr = 1; step(); serTxClr = 0;
    chk("R9 tx sw clear", irqFlags[4], 0);
    chk("R9 no request left", callReq, 0);
    raise(6'b100000);
    chk("R9 rx raises serial", vecAddr, 16'h0023);
    serTxClr = 1; step(); serTxClr = 0;
    chk("R9 tx clear spares rx", irqFlags[5], 1);
    serRxClr = 1; step(); serRxClr = 0;
    chk("R9 rx sw clear", irqFlags[5], 0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #200000;
    failed++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule